// File: doc/BRIEF.md
# Timer Compare Output Unit

This block watches a free-running timer value and a programmed compare value and reacts when the two become equal. The reaction depends on a 4-bit mode code. The output pin can be inverted, forced high, forced low, or given a single one-cycle high pulse. Two of the modes also ask the external timer to clear itself.

Every accepted match does three more things. It raises a sticky interrupt flag, which software clears with a strobe. It emits a one-cycle conversion trigger. In the timer-clearing modes, it emits a one-cycle timer-clear request.

A match is taken once, when equality begins. A timer that stays on the compare value produces no further events. Deasserting the enable drives the pin low and blocks all new events.

Top module: `timer_cmp_out`

## Requirements
- R1: A hit occurs in a cycle where `en_i` is high, `mode_i` is a valid compare code, and all 16 bits of `cmp_val_i` equal `tmr_val_i`, but those conditions did not all hold in the previous cycle. A stretch of consecutive qualifying cycles therefore gives exactly one hit.
- R2: Every hit, whatever the valid mode, drives `trig_o` high for exactly one cycle. That cycle is the one following the hit.
- R3: A hit sets `irq_o` in the next cycle. `irq_o` then stays high until a cycle with `irq_clr_i` high, which clears it in the following cycle. When a hit and `irq_clr_i` fall in the same cycle, the flag ends up set.
- R4: `tmr_clr_o` pulses high for one cycle after a hit only when `mode_i` is 4'b0001 or 4'b1011.
- R5: In modes 4'b0001 and 4'b0010, a hit inverts `pin_o` in the next cycle.
- R6: In mode 4'b1000, a hit drives `pin_o` high. In mode 4'b1001, a hit drives it low. The level then holds.
- R7: In modes 4'b1010 and 4'b1011, a hit drives `pin_o` high for exactly one cycle, after which it returns low.
- R8: A cycle with `en_i` low makes `pin_o` low in the next cycle. It also produces no trigger, no timer-clear request and no interrupt set.
- R9: Any mode code other than the six above is ignored. No hit occurs, and `pin_o` keeps its level.
- R10: While `rst_ni` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Block enable |
| mode_i | input | 4 | Compare action code |
| cmp_val_i | input | 16 | Compare value |
| tmr_val_i | input | 16 | Current timer value |
| irq_clr_i | input | 1 | Software clear strobe for the interrupt flag |
| pin_o | output | 1 | Output pin level |
| tmr_clr_o | output | 1 | One-cycle timer reset request |
| irq_o | output | 1 | Sticky match interrupt flag |
| trig_o | output | 1 | One-cycle conversion trigger |

## Verification
Two events can fall in the same cycle: a hit that sets the interrupt flag, and the software clear strobe. The bench provokes this by asserting `irq_clr_i` in the very cycle the timer reaches the compare value, with the flag already set from an earlier hit. The result is judged against a cycle model built from the requirements, which expects the flag to stay high. The bench also issues a lone clear in a cycle with no hit, and expects the flag to drop.

// File: rtl/tco_pkg.sv
package tco_pkg;
  localparam int MODE_W = 4;

  localparam logic [MODE_W-1:0] MODE_TOG_CLR = 4'b0001;
  localparam logic [MODE_W-1:0] MODE_TOG     = 4'b0010;
  localparam logic [MODE_W-1:0] MODE_SET     = 4'b1000;
  localparam logic [MODE_W-1:0] MODE_CLR     = 4'b1001;
  localparam logic [MODE_W-1:0] MODE_PLS     = 4'b1010;
  localparam logic [MODE_W-1:0] MODE_PLS_CLR = 4'b1011;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_TOGGLE,
    ACT_SET,
    ACT_CLEAR,
    ACT_PULSE
  } pin_act_e;

  typedef struct packed {
    logic     valid;
    pin_act_e act;
    logic     tmr_clr;
  } mode_dec_t;

  function automatic mode_dec_t decode_mode(input logic [MODE_W-1:0] m);
    mode_dec_t d;
    d = '{valid: 1'b1, act: ACT_NONE, tmr_clr: 1'b0};
    unique case (m)
      MODE_TOG_CLR: begin d.act = ACT_TOGGLE; d.tmr_clr = 1'b1; end
      MODE_TOG:     d.act = ACT_TOGGLE;
      MODE_SET:     d.act = ACT_SET;
      MODE_CLR:     d.act = ACT_CLEAR;
      MODE_PLS:     d.act = ACT_PULSE;
      MODE_PLS_CLR: begin d.act = ACT_PULSE; d.tmr_clr = 1'b1; end
      default:      d.valid = 1'b0;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/tco_match.sv
module tco_match #(
  parameter int CMP_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             mode_ok_i,
  input  logic [CMP_W-1:0] cmp_val_i,
  input  logic [CMP_W-1:0] tmr_val_i,
  output logic             hit_o
);
  logic qual, qual_q;

  assign qual  = en_i & mode_ok_i & (cmp_val_i == tmr_val_i);
  assign hit_o = qual & ~qual_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) qual_q <= 1'b0;
    else         qual_q <= qual;
  end

  // two hits need a non-qualifying cycle between them
  assert_no_rehit_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> !hit_o);
endmodule

// File: rtl/tco_pin.sv
module tco_pin
  import tco_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  logic     hit_i,
  input  pin_act_e act_i,
  output logic     pin_o
);
  logic pin_q, pin_d, pulse_q;

  always_comb begin
    pin_d = pin_q;
    if (!en_i) begin
      pin_d = 1'b0;
    end else if (hit_i) begin
      unique case (act_i)
        ACT_TOGGLE: pin_d = ~pin_q;
        ACT_SET:    pin_d = 1'b1;
        ACT_CLEAR:  pin_d = 1'b0;
        ACT_PULSE:  pin_d = 1'b1;
        default:    pin_d = pin_q;
      endcase
    end else if (pulse_q) begin
      pin_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pin_q   <= pin_d;
      pulse_q <= en_i & hit_i & (act_i == ACT_PULSE);
    end
  end

  assign pin_o = pin_q;

  assert_pulse_one_cycle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |=> !pin_q);
  assert_pulse_high_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |-> pin_q);
  assert_disabled_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pin_q);
endmodule

// File: rtl/tco_events.sv
module tco_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic tmr_clr_mode_i,
  input  logic irq_clr_i,
  output logic trig_o,
  output logic tmr_clr_o,
  output logic irq_o
);
  logic trig_q, tclr_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q <= 1'b0;
      tclr_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      trig_q <= hit_i;
      tclr_q <= hit_i & tmr_clr_mode_i;
      // a hit outranks a simultaneous clear
      if (hit_i)          irq_q <= 1'b1;
      else if (irq_clr_i) irq_q <= 1'b0;
    end
  end

  assign trig_o    = trig_q;
  assign tmr_clr_o = tclr_q;
  assign irq_o     = irq_q;

  assert_trig_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_q |=> !trig_q);
  assert_irq_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> trig_q);
  assert_irq_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !irq_clr_i) |=> irq_q);
  assert_tclr_with_trig_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tclr_q |-> trig_q);
endmodule

// File: rtl/timer_cmp_out.sv
module timer_cmp_out
  import tco_pkg::*;
#(
  parameter int CMP_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [CMP_W-1:0]  cmp_val_i,
  input  logic [CMP_W-1:0]  tmr_val_i,
  input  logic              irq_clr_i,
  output logic              pin_o,
  output logic              tmr_clr_o,
  output logic              irq_o,
  output logic              trig_o
);
  mode_dec_t dec;
  logic      hit;

  assign dec = decode_mode(mode_i);

  tco_match #(.CMP_W(CMP_W)) u_match (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .mode_ok_i (dec.valid),
    .cmp_val_i (cmp_val_i),
    .tmr_val_i (tmr_val_i),
    .hit_o     (hit)
  );

  tco_pin u_pin (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .hit_i  (hit),
    .act_i  (dec.act),
    .pin_o  (pin_o)
  );

  tco_events u_events (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .hit_i          (hit),
    .tmr_clr_mode_i (dec.tmr_clr),
    .irq_clr_i      (irq_clr_i),
    .trig_o         (trig_o),
    .tmr_clr_o      (tmr_clr_o),
    .irq_o          (irq_o)
  );

  assert_tclr_mode_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_clr_o |-> ($past(mode_i) == MODE_TOG_CLR || $past(mode_i) == MODE_PLS_CLR));
  assert_disabled_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!trig_o && !tmr_clr_o));
  assert_bad_mode_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec.valid |=> !trig_o);
endmodule

// File: tb/timer_cmp_out_bench.sv
module timer_cmp_out_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [3:0]  mode_i = 4'd0;
  logic [15:0] cmp_val_i = 16'd0;
  logic [15:0] tmr_val_i = 16'd1;
  logic        irq_clr_i = 1'b0;
  logic        pin_o, tmr_clr_o, irq_o, trig_o;

  int tests = 0, fails = 0, trig_seen = 0;
  bit done = 0;
  logic m_prev = 0, m_pulse = 0, e_pin = 0, e_irq = 0, e_trig = 0, e_tclr = 0;

  timer_cmp_out u_timer_cmp_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .mode_i(mode_i),
    .cmp_val_i(cmp_val_i), .tmr_val_i(tmr_val_i), .irq_clr_i(irq_clr_i),
    .pin_o(pin_o), .tmr_clr_o(tmr_clr_o), .irq_o(irq_o), .trig_o(trig_o)
  );

  always #10 clk_i = ~clk_i;

  function automatic bit valid_mode(input logic [3:0] m);
    return m == 4'b0001 || m == 4'b0010 || m == 4'b1000 ||
           m == 4'b1001 || m == 4'b1010 || m == 4'b1011;
  endfunction

  function automatic string pin_tag(input logic [3:0] m, input logic en);
    if (!en) return "R8 pin";
    case (m)
      4'b0001, 4'b0010: return "R5 pin";
      4'b1000, 4'b1001: return "R6 pin";
      4'b1010, 4'b1011: return "R7 pin";
      default:          return "R9 pin";
    endcase
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b (mode %b t=%0t)", tag, act, exp, mode_i, $time);
    end
  endtask

  // one clock: model next state from current inputs, then compare at negedge
  task automatic step();
    logic qual, hit, n_pin;
    qual = en_i && valid_mode(mode_i) && (cmp_val_i == tmr_val_i);
    hit  = qual && !m_prev;
    n_pin = e_pin;
    if (!en_i) n_pin = 1'b0;
    else if (hit) begin
      case (mode_i)
        4'b0001, 4'b0010: n_pin = ~e_pin;
        4'b1000, 4'b1010, 4'b1011: n_pin = 1'b1;
        4'b1001: n_pin = 1'b0;
        default: n_pin = e_pin;
      endcase
    end else if (m_pulse) n_pin = 1'b0;
    @(posedge clk_i);
    @(negedge clk_i);
    m_pulse = en_i && hit && (mode_i == 4'b1010 || mode_i == 4'b1011);
    m_prev  = qual;
    e_pin   = n_pin;
    e_trig  = hit;
    e_tclr  = hit && (mode_i == 4'b0001 || mode_i == 4'b1011);
    if (hit) e_irq = 1'b1; else if (irq_clr_i) e_irq = 1'b0;
    if (trig_o) trig_seen++;
    check(pin_tag(mode_i, en_i), pin_o, e_pin);
    check(en_i ? "R2 trig" : "R8 trig", trig_o, e_trig);
    check("R4 tmr_clr", tmr_clr_o, e_tclr);
    check("R3 irq", irq_o, e_irq);
  endtask

  task automatic drive_tmr(input logic [15:0] v);
    tmr_val_i = v;
    step();
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R10 pin", pin_o, 1'b0);
    check("R10 trig", trig_o, 1'b0);
    check("R10 tmr_clr", tmr_clr_o, 1'b0);
    check("R10 irq", irq_o, 1'b0);
    rst_ni = 1'b1;

    // sweep every mode code: two separate entries into equality plus a hold
    for (int m = 0; m < 16; m++) begin
      en_i = 1'b0; irq_clr_i = 1'b1; step(); irq_clr_i = 1'b0;
      mode_i = 4'(m); cmp_val_i = 16'h1200 + 16'(m * 37); en_i = 1'b1;
      trig_seen = 0;
      drive_tmr(cmp_val_i - 16'd2);
      drive_tmr(cmp_val_i - 16'd1);
      drive_tmr(cmp_val_i);
      drive_tmr(cmp_val_i);
      drive_tmr(cmp_val_i);
      drive_tmr(cmp_val_i ^ 16'h8000);
      drive_tmr(cmp_val_i);
      drive_tmr(cmp_val_i + 16'd1);
      drive_tmr(cmp_val_i + 16'd2);
      drive_tmr(cmp_val_i + 16'd3);
      check("R1 hit count", trig_seen == (valid_mode(4'(m)) ? 2 : 0), 1'b1);
    end

    // hit and software clear in the same cycle: flag must stay set
    mode_i = 4'b0010; cmp_val_i = 16'h0042; en_i = 1'b1;
    drive_tmr(16'h0041);
    drive_tmr(16'h0042);
    drive_tmr(16'h0043);
    tmr_val_i = 16'h0042; irq_clr_i = 1'b1; step(); irq_clr_i = 1'b0;
    check("R3 set beats clear", irq_o, 1'b1);
    drive_tmr(16'h0044);
    irq_clr_i = 1'b1; step(); irq_clr_i = 1'b0;
    check("R3 lone clear", irq_o, 1'b0);

    // wrap boundary with all-ones compare value
    mode_i = 4'b1011; cmp_val_i = 16'hFFFF;
    drive_tmr(16'hFFFE);
    drive_tmr(16'hFFFF);
    drive_tmr(16'h0000);
    drive_tmr(16'h0001);

    // enable rises while already equal: one hit
    en_i = 1'b0; tmr_val_i = 16'hFFFF; step();
    mode_i = 4'b1000; en_i = 1'b1; step(); step(); step();
    check("R1 enable-while-equal pin", pin_o, 1'b1);

    // switching between valid modes while equal: no new hit
    mode_i = 4'b1001; step(); step();
    check("R1 no refire on mode change", pin_o, 1'b1);
    // invalid code then back to valid while equal: requalifies
    mode_i = 4'b0111; step();
    mode_i = 4'b1001; step(); step();
    check("R9 requalify after invalid", pin_o, 1'b0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule